// File: doc/BRIEF.md
# Event Timestamp Capture Bank

This block snapshots a free-running 64-bit nanosecond time value when a precision-time event frame crosses the port. It has four receive capture slots and one transmit capture slot. A receive event that passes the configured qualifier is stored in the lowest-numbered free receive slot. The slot then stays locked until software reads its upper word. The number of the slot used is handed back to the receive path one cycle later, so that it can travel with the frame.

Software reads each slot through a word-wide read port, taking the lower word first and the upper word second. The upper-word read frees the slot. A transmit capture locks the transmit slot and can raise an interrupt. The qualifier works on classification inputs that the frame parser supplies:
- the protocol version of the frame;
- whether the frame arrived over UDP or directly at layer 2;
- its message type.

The control inputs select which version is matched, a per-message-type mask, UDP recognition, and a global enable that is separate from the type fields.

Top module: `tstamp_latch_bank`

## Requirements
- R1: After reset, all receive occupancy bits, the overflow flag, the transmit lock, the transmit interrupt and the slot-index valid output are 0.
- R2: A qualified receive event is stored in the lowest-numbered free slot, and that slot's occupancy bit is set. On the following cycle `rxIdxValid` is 1 for one cycle and `rxIdx` carries the slot number.
- R3: Reading a slot with `rdHigh`=0 returns bits 31:0 of the time sampled at the capture edge, and `rdHigh`=1 returns bits 63:32. A locked slot's contents never change.
- R4: A read with `rdHigh`=1 of receive slot n (`rdSlot`=n, 0..3) clears occupancy bit n on that clock edge. A read with `rdHigh`=0 leaves occupancy unchanged.
- R5: When all four receive slots are occupied, a qualified receive event is dropped, no index is reported, and `rxOverflow` is set. `rxOverflow` stays set until reset.
- R6: With `cfgVerV2`=0, only events with `rxIsV2`=0 and `rxOverUdp`=1 qualify, and only while `cfgUdpEn`=1. With `cfgUdpEn`=0 in this mode, no receive event is ever captured.
- R7: With `cfgVerV2`=1, only events with `rxIsV2`=1 qualify. Layer-2 events (`rxOverUdp`=0) always qualify. UDP events qualify only while `cfgUdpEn`=1.
- R8: A receive event qualifies only if bit `rxMsgType` of `cfgTypeMask` is 1.
- R9: While `cfgEnable`=0, no receive or transmit event is captured.
- R10: A transmit event captures the time into the transmit slot (`rdSlot`=4) and sets `txLocked`. A transmit event that arrives while the slot is locked is ignored. A read of slot 4 with `rdHigh`=1 clears `txLocked`.
- R11: A transmit capture sets `txIrq` only when `cfgTxIntEn`=1. The upper-word read of the transmit slot clears `txIrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgEnable | input | 1 | Global capture enable |
| cfgVerV2 | input | 1 | 1: match version 2 events; 0: match version 1 events |
| cfgUdpEn | input | 1 | UDP recognition enable |
| cfgTypeMask | input | 16 | One enable bit per message type |
| cfgTxIntEn | input | 1 | Transmit capture interrupt enable |
| timeNow | input | 64 | Current time in nanoseconds |
| rxEvent | input | 1 | Receive event pulse |
| rxIsV2 | input | 1 | Frame is version 2 |
| rxOverUdp | input | 1 | Frame was carried over UDP (0: layer 2) |
| rxMsgType | input | 4 | Message type of the frame |
| txEvent | input | 1 | Transmit event pulse |
| rdEn | input | 1 | Read strobe |
| rdSlot | input | 3 | Slot to read: 0..3 receive, 4 transmit |
| rdHigh | input | 1 | 1: upper word (releases the slot); 0: lower word |
| rdData | output | 32 | Selected word, combinational |
| rxOcc | output | 4 | Receive slot occupancy status |
| rxOverflow | output | 1 | Sticky flag: receive event lost, all slots full |
| txLocked | output | 1 | Transmit slot holds an unread capture |
| txIrq | output | 1 | Transmit capture interrupt |
| rxIdxValid | output | 1 | Slot index valid for the last receive capture |
| rxIdx | output | 2 | Slot index used for the last receive capture |

## Verification
A wrong allocation shows up on `rxIdx` one cycle after the event. The scoreboard compares each reported index with the expected slot, and compares the slot's stored time when the slot is read back.

A stuck or missed release shows up at the next event. Either a slot number is skipped, or a drop sets `rxOverflow` early, within the same event.

Faulty qualification shows up as an unexpected index report, or as an occupancy vector that changed when nothing should have been captured. These are visible on the cycle after the stimulus.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int RX_SLOTS = 4;

  typedef struct packed {
    logic [RX_SLOTS-1:0] rxCapture;
    logic                txCapture;
  } tsl_strobe_t;
endpackage

// File: rtl/tsl_ctrl.sv
module tsl_ctrl
  import tsl_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfgEnable,
  input  logic                   cfgVerV2,
  input  logic                   cfgUdpEn,
  input  logic [(1<<TYPE_W)-1:0] cfgTypeMask,
  input  logic                   cfgTxIntEn,
  input  logic                   rxEvent,
  input  logic                   rxIsV2,
  input  logic                   rxOverUdp,
  input  logic [TYPE_W-1:0]      rxMsgType,
  input  logic                   txEvent,
  input  logic                   rdEn,
  input  logic [SEL_W-1:0]       rdSlot,
  input  logic                   rdHigh,
  output tsl_strobe_t            strb,
  output logic [RX_SLOTS-1:0]    rxOcc,
  output logic                   rxOverflow,
  output logic                   txLocked,
  output logic                   txIrq,
  output logic                   rxIdxValid,
  output logic [$clog2(RX_SLOTS)-1:0] rxIdx
);
  localparam int IDX_W = $clog2(RX_SLOTS);

  logic                verOk, rxQual, anyFree, txRel;
  logic [IDX_W-1:0]    pick;
  logic [RX_SLOTS-1:0] rxRel;

  always_comb begin
    if (cfgVerV2) verOk = rxIsV2 && (!rxOverUdp || cfgUdpEn);
    else          verOk = !rxIsV2 && rxOverUdp && cfgUdpEn;
  end

  assign rxQual  = cfgEnable && rxEvent && cfgTypeMask[rxMsgType] && verOk;
  assign anyFree = |(~rxOcc);

  always_comb begin
    pick = '0;
    for (int i = RX_SLOTS - 1; i >= 0; i--)
      if (!rxOcc[i]) pick = IDX_W'(i);
  end

  always_comb begin
    strb.rxCapture = '0;
    if (rxQual && anyFree) strb.rxCapture[pick] = 1'b1;
    strb.txCapture = cfgEnable && txEvent && !txLocked;
  end

  for (genvar g = 0; g < RX_SLOTS; g++) begin : g_rel
    assign rxRel[g] = rdEn && rdHigh && (rdSlot == SEL_W'(g));
  end
  assign txRel = rdEn && rdHigh && (rdSlot == SEL_W'(RX_SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxOcc      <= '0;
      rxOverflow <= 1'b0;
      txLocked   <= 1'b0;
      txIrq      <= 1'b0;
      rxIdxValid <= 1'b0;
      rxIdx      <= '0;
    end else begin
      rxOcc      <= (rxOcc & ~rxRel) | strb.rxCapture;
      if (rxQual && !anyFree) rxOverflow <= 1'b1;
      txLocked   <= (txLocked && !txRel) || strb.txCapture;
      if (txRel) txIrq <= 1'b0;
      if (strb.txCapture && cfgTxIntEn) txIrq <= 1'b1;
      rxIdxValid <= |strb.rxCapture;
      rxIdx      <= pick;
    end
  end

  // R2: at most one slot captures per event, always a free one
  p_onehot_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb.rxCapture) && ((strb.rxCapture & rxOcc) == '0));
  // R5: full bank never captures; overflow is sticky
  p_full_nocap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&rxOcc) |-> (strb.rxCapture == '0));
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rxOverflow |=> rxOverflow);
  // R10: a locked transmit slot is not recaptured
  p_tx_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txLocked |-> !strb.txCapture);
  // R11: interrupt rises only with its enable
  p_irq_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txIrq) |-> $past(cfgTxIntEn));
endmodule

// File: rtl/tsl_data.sv
module tsl_data
  import tsl_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int WORD_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tsl_strobe_t        strb,
  input  logic [TIME_W-1:0]  timeNow,
  input  logic [SEL_W-1:0]   rdSlot,
  input  logic               rdHigh,
  output logic [WORD_W-1:0]  rdData
);
  localparam int IDX_W = $clog2(RX_SLOTS);

  logic [RX_SLOTS-1:0][TIME_W-1:0] rxTime;
  logic [TIME_W-1:0]               txTime, selTime;

  for (genvar g = 0; g < RX_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rxTime[g] <= '0;
      else if (strb.rxCapture[g]) rxTime[g] <= timeNow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              txTime <= '0;
    else if (strb.txCapture) txTime <= timeNow;
  end

  always_comb begin
    if (rdSlot < SEL_W'(RX_SLOTS)) selTime = rxTime[rdSlot[IDX_W-1:0]];
    else                           selTime = txTime;
    rdData = rdHigh ? selTime[TIME_W-1:WORD_W] : selTime[WORD_W-1:0];
  end

  // R3: stored receive times change only on a capture strobe
  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rxCapture == '0) |=> $stable(rxTime));
  // R10: transmit time changes only on a transmit capture
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.txCapture |=> $stable(txTime));
endmodule

// File: rtl/tstamp_latch_bank.sv
module tstamp_latch_bank
  import tsl_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int WORD_W = 32,
  parameter int TYPE_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfgEnable,
  input  logic                        cfgVerV2,
  input  logic                        cfgUdpEn,
  input  logic [(1<<TYPE_W)-1:0]      cfgTypeMask,
  input  logic                        cfgTxIntEn,
  input  logic [TIME_W-1:0]           timeNow,
  input  logic                        rxEvent,
  input  logic                        rxIsV2,
  input  logic                        rxOverUdp,
  input  logic [TYPE_W-1:0]           rxMsgType,
  input  logic                        txEvent,
  input  logic                        rdEn,
  input  logic [SEL_W-1:0]            rdSlot,
  input  logic                        rdHigh,
  output logic [WORD_W-1:0]           rdData,
  output logic [RX_SLOTS-1:0]         rxOcc,
  output logic                        rxOverflow,
  output logic                        txLocked,
  output logic                        txIrq,
  output logic                        rxIdxValid,
  output logic [$clog2(RX_SLOTS)-1:0] rxIdx
);
  tsl_strobe_t strb;

  tsl_ctrl #(.TYPE_W(TYPE_W), .SEL_W(SEL_W)) u_ctrl (
    .clk, .rst_n, .cfgEnable, .cfgVerV2, .cfgUdpEn, .cfgTypeMask, .cfgTxIntEn,
    .rxEvent, .rxIsV2, .rxOverUdp, .rxMsgType, .txEvent,
    .rdEn, .rdSlot, .rdHigh, .strb, .rxOcc, .rxOverflow, .txLocked, .txIrq,
    .rxIdxValid, .rxIdx
  );

  tsl_data #(.TIME_W(TIME_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_data (
    .clk, .rst_n, .strb, .timeNow, .rdSlot, .rdHigh, .rdData
  );
endmodule

// File: tb/tb_tstamp_latch_bank.sv
module tb_tstamp_latch_bank;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfgEnable = 1'b0, cfgVerV2 = 1'b1, cfgUdpEn = 1'b1, cfgTxIntEn = 1'b1;
  logic [15:0] cfgTypeMask = 16'h000F;
  logic [63:0] timeNow = 64'h0000_0001_FFFF_FF00;
  logic        rxEvent = 1'b0, rxIsV2 = 1'b0, rxOverUdp = 1'b0, txEvent = 1'b0;
  logic [3:0]  rxMsgType = '0;
  logic        rdEn = 1'b0, rdHigh = 1'b0;
  logic [2:0]  rdSlot = '0;
  logic [31:0] rdData;
  logic [3:0]  rxOcc;
  logic        rxOverflow, txLocked, txIrq, rxIdxValid;
  logic [1:0]  rxIdx;

  int errors = 0, checks = 0;
  int expIdxQ[$];
  logic [63:0] expRx[4];
  logic [63:0] expTx;
  logic [31:0] w;

  tstamp_latch_bank dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) timeNow <= timeNow + 64'd13;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected slot indices as the design reports them
  always @(negedge clk) begin
    if (rst_n && rxIdxValid) begin
      if (expIdxQ.size() == 0) chk("R2 unexpected index", {62'd0, rxIdx}, 64'hFFFF);
      else chk("R2 slot index", {62'd0, rxIdx}, 64'(expIdxQ.pop_front()));
    end
  end

  // driver: expIdx < 0 means the event must not be captured
  task automatic sendRx(logic v2, logic udp, logic [3:0] mt, int expIdx);
    @(negedge clk);
    rxIsV2 = v2; rxOverUdp = udp; rxMsgType = mt; rxEvent = 1'b1;
    if (expIdx >= 0) begin
      expIdxQ.push_back(expIdx);
      expRx[expIdx] = timeNow;
    end
    @(negedge clk);
    rxEvent = 1'b0;
  endtask

  task automatic sendTx(logic expCap);
    @(negedge clk);
    txEvent = 1'b1;
    if (expCap) expTx = timeNow;
    @(negedge clk);
    txEvent = 1'b0;
  endtask

  task automatic rd(logic [2:0] slot, logic hi, output logic [31:0] data);
    @(negedge clk);
    rdEn = 1'b1; rdSlot = slot; rdHigh = hi;
    #1 data = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readSlot(logic [2:0] slot, logic [63:0] exp, string req);
    rd(slot, 1'b0, w); chk(req, {32'd0, w}, {32'd0, exp[31:0]});
    rd(slot, 1'b1, w); chk(req, {32'd0, w}, {32'd0, exp[63:32]});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R1 occupancy", {60'd0, rxOcc}, 64'd0);
    chk("R1 flags", {59'd0, rxOverflow, txLocked, txIrq, rxIdxValid, 1'b0}, 64'd0);
    rst_n = 1'b1;
    cfgEnable = 1'b1;

    // R7: version 2 over L2 and over UDP; R2 lowest free slot
    sendRx(1, 0, 0, 0);
    sendRx(1, 1, 1, 1);
    chk("R2 occupancy", {60'd0, rxOcc}, 64'b0011);
    rd(0, 1'b0, w); chk("R3 low word", {32'd0, w}, {32'd0, expRx[0][31:0]});
    chk("R4 low read keeps slot", {60'd0, rxOcc}, 64'b0011);
    rd(0, 1'b1, w); chk("R3 high word", {32'd0, w}, {32'd0, expRx[0][63:32]});
    chk("R4 high read frees slot", {60'd0, rxOcc}, 64'b0010);

    // R2 refill lowest free, then fill the bank; R5 overflow
    sendRx(1, 0, 2, 0);
    sendRx(1, 0, 3, 2);
    sendRx(1, 1, 0, 3);
    chk("R2 bank full", {60'd0, rxOcc}, 64'b1111);
    chk("R5 no overflow yet", {63'd0, rxOverflow}, 64'd0);
    sendRx(1, 0, 0, -1);
    chk("R5 overflow set", {63'd0, rxOverflow}, 64'd1);
    chk("R5 bank unchanged", {60'd0, rxOcc}, 64'b1111);
    readSlot(3, expRx[3], "R3 slot3 data");
    readSlot(2, expRx[2], "R3 slot2 data");

    // R8 type mask
    sendRx(1, 0, 5, -1);
    chk("R8 masked type ignored", {60'd0, rxOcc}, 64'b0011);
    sendRx(1, 0, 2, 2);
    chk("R8 enabled type captured", {60'd0, rxOcc}, 64'b0111);

    // R7 UDP recognition off
    readSlot(1, expRx[1], "R3 slot1 data");
    cfgUdpEn = 1'b0;
    sendRx(1, 1, 0, -1);
    chk("R7 v2 UDP ignored", {60'd0, rxOcc}, 64'b0101);
    sendRx(0, 0, 0, -1);
    chk("R7 v1 ignored in v2 mode", {60'd0, rxOcc}, 64'b0101);
    sendRx(1, 0, 1, 1);
    chk("R7 v2 L2 captured", {60'd0, rxOcc}, 64'b0111);
    readSlot(1, expRx[1], "R3 slot1 data");

    // R6 version 1 mode
    cfgVerV2 = 1'b0;
    sendRx(0, 1, 0, -1);
    chk("R6 v1 without UDP recognition", {60'd0, rxOcc}, 64'b0101);
    cfgUdpEn = 1'b1;
    sendRx(0, 0, 0, -1);
    sendRx(1, 0, 0, -1);
    chk("R6 v1 L2 and v2 ignored", {60'd0, rxOcc}, 64'b0101);
    sendRx(0, 1, 3, 1);
    chk("R6 v1 UDP captured", {60'd0, rxOcc}, 64'b0111);
    readSlot(1, expRx[1], "R6 slot1 data");

    // R9 global enable
    cfgEnable = 1'b0;
    sendRx(0, 1, 0, -1);
    sendTx(1'b0);
    chk("R9 disabled", {59'd0, rxOcc, txLocked}, 64'b01010);
    cfgEnable = 1'b1;

    // R10/R11 transmit slot
    sendTx(1'b1);
    chk("R10 tx locked", {63'd0, txLocked}, 64'd1);
    chk("R11 irq set", {63'd0, txIrq}, 64'd1);
    sendTx(1'b0);
    readSlot(4, expTx, "R10 tx keeps first capture");
    chk("R10 tx unlocked", {63'd0, txLocked}, 64'd0);
    chk("R11 irq cleared", {63'd0, txIrq}, 64'd0);
    cfgTxIntEn = 1'b0;
    sendTx(1'b1);
    chk("R11 no irq when disabled", {62'd0, txLocked, txIrq}, 64'b10);
    readSlot(4, expTx, "R10 tx data");

    chk("R5 overflow sticky", {63'd0, rxOverflow}, 64'd1);
    chk("R2 scoreboard drained", 64'(expIdxQ.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule